// File: doc/BRIEF.md
# Dual-Protocol Host Bus Slave with Mirrored Register Banks

This block connects an 8-bit asynchronous host processor to a small external register file. A single set of bus pins can be read in two ways. In the strobe mode there are separate active-low read and write strobes, and the status pin is a ready line that drops for a fixed time at the start of each access. In the data-strobe mode there is one active-low data strobe and a read/write select line, and the status pin is an active-low transfer acknowledge. It asserts once the access is done and releases when the strobe is removed. A static mode input picks the protocol.

A 3-bit address picks one of eight registers. There are two chip selects, and each one opens its own copy of the register bank. One copy serves the lower half of the channels and their ports, and the other serves the upper half. The two copies have the same layout. Each committed write is also shown on a register-bank write port, so the logic behind the registers can follow it. A second requester, the serial control path, uses the same two banks through its own port. The host takes priority whenever both try to write in the same cycle.

Top module: `hostport_top`

## Requirements
- R1: In strobe mode (`mode_sel`=0), while exactly one chip select is low and `strb_a_n` (read strobe) is low, `bus_oe` is 1 and `bus_dout` carries the addressed register of the selected bank. At all other times `bus_oe` is 0.
- R2: In strobe mode, driving `strb_b` (write strobe) low and then high writes `bus_din` into the addressed register when the strobe goes high. In that commit cycle `reg_we` pulses for one cycle with `reg_bank`, `reg_addr` and `reg_wdata` equal to the access.
- R3: In data-strobe mode (`mode_sel`=1), `strb_a_n` is the data strobe and `strb_b` is read/write (1 = read, 0 = write). A read drives the bus as in R1. A write commits when the data strobe is released, as in R2.
- R4: `cs_n`=2'b10 (bit 0 low) selects bank 0 and `cs_n`=2'b01 (bit 1 low) selects bank 1. The banks use the same addresses and hold separate contents.
- R5: When both chip selects are low (`cs_n`=2'b00), the access is ignored: nothing is written, `reg_we` stays 0, `bus_oe` stays 0 and the status pin stays idle.
- R6: In strobe mode, `stat_o` (ready) is 1 when idle. Two clocks after an access starts, it goes to 0 for exactly RDY_WAIT clocks and then returns to 1, even if the strobe is still held.
- R7: In data-strobe mode, `stat_o` (acknowledge, active low) is 1 when idle. It goes to 0 RDY_WAIT+2 clocks after the access starts, stays 0 while the strobe is held, and returns to 1 within three clocks after the strobe is released.
- R8: The serial port reads any register through `ser_rdata`, combinationally from `ser_bank`/`ser_addr`. With `ser_req` and `ser_we` high, it writes in every cycle where `ser_gnt` is 1. `ser_gnt` is 0 only in a cycle where a host write commits, and the host write wins.
- R9: After reset, every register in both banks reads 0, `bus_oe` is 0 and `stat_o` is 1.
- R10: `mode_sel` may change only while both chip selects are high. The new protocol applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | 0 = separate strobes with ready, 1 = data strobe with acknowledge |
| cs_n | input | 2 | Active-low chip selects, one per bank |
| strb_a_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| strb_b | input | 1 | Write strobe, active low (mode 0), or read/write select (mode 1) |
| addr | input | AW | Register address |
| bus_din | input | DW | Host write data |
| bus_dout | output | DW | Host read data |
| bus_oe | output | 1 | Drive enable for the host data bus |
| stat_o | output | 1 | Ready (mode 0) or active-low acknowledge (mode 1) |
| ser_req | input | 1 | Serial requester wants the register file |
| ser_we | input | 1 | Serial write enable |
| ser_bank | input | 1 | Serial bank select |
| ser_addr | input | AW | Serial register address |
| ser_wdata | input | DW | Serial write data |
| ser_gnt | output | 1 | Serial request granted this cycle |
| ser_rdata | output | DW | Serial read data |
| reg_we | output | 1 | Register-bank write strobe |
| reg_bank | output | 1 | Bank of the committed write |
| reg_addr | output | AW | Address of the committed write |
| reg_wdata | output | DW | Data of the committed write |

## Verification
The bench builds the block with its defaults: 8-bit data, 3-bit address and RDY_WAIT = 4. That is small enough to write and read back every register of both banks under both protocols, and to count every status cycle of each access exactly. Because the wait is short, the full ready pulse, the delayed acknowledge and the release all fall inside the held strobe window. The serial requester is kept asserted across a host commit, so the one-cycle loss of grant is visible.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int HP_DW = 8;
  localparam int HP_AW = 3;
  localparam int HP_NBANK = 2;

  typedef enum logic {
    PROTO_STROBES = 1'b0,
    PROTO_DSRW    = 1'b1
  } proto_e;

  // exactly one active-low chip select asserted
  function automatic logic cs_single(input logic [HP_NBANK-1:0] csn);
    return $countones(~csn) == 1;
  endfunction

  // bank index for an active-low one-hot select (bit 1 low -> bank 1)
  function automatic logic cs_bank(input logic [HP_NBANK-1:0] csn);
    return ~csn[1];
  endfunction

  // status counter step: reload on a new access, else count to zero
  function automatic int unsigned cnt_next(input int unsigned cur,
                                           input logic start,
                                           input int unsigned wait_len);
    if (start) return wait_len;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/hp_decode.sv
module hp_decode
  import hp_pkg::*;
#(
  parameter int AW = HP_AW,
  parameter int DW = HP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [1:0]    s_cs_n,
  input  logic          s_a_n,
  input  logic          s_b,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          sel_ok,
  output logic          sel_bank,
  output logic          rd_act,
  output logic          wr_act,
  output logic          acc_act,
  output logic          host_commit,
  output logic          cm_bank,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data
);
  proto_e proto;
  logic   wr_q;

  assign proto    = proto_e'(mode_sel);
  assign sel_ok   = cs_single(s_cs_n);
  assign sel_bank = cs_bank(s_cs_n);

  always_comb begin
    rd_act = 1'b0;
    wr_act = 1'b0;
    case (proto)
      PROTO_STROBES: begin
        rd_act = sel_ok & ~s_a_n;
        wr_act = sel_ok & s_a_n & ~s_b;
      end
      PROTO_DSRW: begin
        rd_act = sel_ok & ~s_a_n & s_b;
        wr_act = sel_ok & ~s_a_n & ~s_b;
      end
      default: ;
    endcase
  end

  assign acc_act     = rd_act | wr_act;
  assign host_commit = wr_q & ~wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      cm_bank <= 1'b0;
      cm_addr <= '0;
      cm_data <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act) begin
        cm_bank <= sel_bank;
        cm_addr <= addr;
        cm_data <= din;
      end
    end
  end
endmodule

// File: rtl/hp_handshake.sv
module hp_handshake
  import hp_pkg::*;
#(
  parameter int RDY_WAIT = 4,
  localparam int CW = $clog2(RDY_WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic acc_act,
  output logic acc_rise,
  output logic wait_done,
  output logic stat_o
);
  logic [CW-1:0] cnt;
  logic          acc_q;
  proto_e        proto;

  assign proto     = proto_e'(mode_sel);
  assign acc_rise  = acc_act & ~acc_q;
  assign wait_done = (cnt == '0) & acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      acc_q <= 1'b0;
    end else begin
      acc_q <= acc_act;
      cnt   <= CW'(cnt_next(int'(cnt), acc_rise, RDY_WAIT));
    end
  end

  always_comb begin
    case (proto)
      PROTO_STROBES: stat_o = (cnt == '0);
      PROTO_DSRW:    stat_o = ~(acc_act & wait_done);
      default:       stat_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/hp_regbank.sv
module hp_regbank
  import hp_pkg::*;
#(
  parameter int AW = HP_AW,
  parameter int DW = HP_DW,
  parameter int NB = HP_NBANK,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          host_bank,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ser_req,
  input  logic          ser_we,
  input  logic          ser_bank,
  input  logic [AW-1:0] ser_addr,
  input  logic [DW-1:0] ser_wdata,
  output logic          ser_gnt,
  output logic [DW-1:0] ser_rdata,
  output logic          reg_we,
  output logic          reg_bank,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata
);
  logic [DW-1:0] host_word [NB];
  logic [DW-1:0] ser_word  [NB];

  assign ser_gnt   = ser_req & ~host_we;
  assign reg_we    = host_we | (ser_gnt & ser_we);
  assign reg_bank  = host_we ? host_bank  : ser_bank;
  assign reg_addr  = host_we ? host_addr  : ser_addr;
  assign reg_wdata = host_we ? host_wdata : ser_wdata;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          hit;

    assign hit = reg_we & (reg_bank == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (hit) begin
        mem[reg_addr] <= reg_wdata;
      end
    end

    assign host_word[b] = mem[rd_addr];
    assign ser_word[b]  = mem[ser_addr];
  end

  assign rd_data   = host_word[rd_bank];
  assign ser_rdata = ser_word[ser_bank];
endmodule

// File: rtl/hostport_top.sv
module hostport_top
  import hp_pkg::*;
#(
  parameter int AW = HP_AW,
  parameter int DW = HP_DW,
  parameter int RDY_WAIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [1:0]    cs_n,
  input  logic          strb_a_n,
  input  logic          strb_b,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          stat_o,
  input  logic          ser_req,
  input  logic          ser_we,
  input  logic          ser_bank,
  input  logic [AW-1:0] ser_addr,
  input  logic [DW-1:0] ser_wdata,
  output logic          ser_gnt,
  output logic [DW-1:0] ser_rdata,
  output logic          reg_we,
  output logic          reg_bank,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata
);
  logic [3:0]    s_bus;
  logic [1:0]    s_cs_n;
  logic          s_a_n;
  logic          s_b;
  logic          sel_ok;
  logic          sel_bank;
  logic          rd_act;
  logic          wr_act;
  logic          acc_act;
  logic          host_commit;
  logic          cm_bank;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;
  logic          acc_rise;
  logic          wait_done;
  logic [DW-1:0] rd_data;

  hp_sync #(.W(4), .RST_VAL(4'b1111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, strb_a_n, strb_b}),
    .q(s_bus)
  );
  assign s_cs_n = s_bus[3:2];
  assign s_a_n  = s_bus[1];
  assign s_b    = s_bus[0];

  hp_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .s_cs_n(s_cs_n), .s_a_n(s_a_n), .s_b(s_b),
    .addr(addr), .din(bus_din),
    .sel_ok(sel_ok), .sel_bank(sel_bank),
    .rd_act(rd_act), .wr_act(wr_act), .acc_act(acc_act),
    .host_commit(host_commit),
    .cm_bank(cm_bank), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  hp_handshake #(.RDY_WAIT(RDY_WAIT)) u_hs (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .acc_act(acc_act), .acc_rise(acc_rise),
    .wait_done(wait_done), .stat_o(stat_o)
  );

  hp_regbank #(.AW(AW), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_commit), .host_bank(cm_bank),
    .host_addr(cm_addr), .host_wdata(cm_data),
    .rd_bank(sel_bank), .rd_addr(addr), .rd_data(rd_data),
    .ser_req(ser_req), .ser_we(ser_we), .ser_bank(ser_bank),
    .ser_addr(ser_addr), .ser_wdata(ser_wdata),
    .ser_gnt(ser_gnt), .ser_rdata(ser_rdata),
    .reg_we(reg_we), .reg_bank(reg_bank),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  assign bus_oe   = rd_act;
  assign bus_dout = rd_act ? rd_data : '0;
endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
  parameter int RDY_WAIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_sel,
  input logic [1:0] cs_n,
  input logic       bus_oe,
  input logic       stat_o,
  input logic       host_commit,
  input logic       reg_we,
  input logic       ser_req,
  input logic       ser_gnt,
  input logic       acc_act
);
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (!mode_sel && !stat_o) low_run <= low_run + 1;
    else low_run <= 0;
  end

  // R1
  oe_needs_single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ($past(cs_n, 2) == 2'b01 || $past(cs_n, 2) == 2'b10));

  // R5
  conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n, 2) == 2'b00) |-> (!bus_oe && !acc_act));

  // R2
  commit_reaches_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_commit |-> reg_we);

  // R8
  host_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_commit && ser_req) |-> !ser_gnt);

  // R6
  ready_low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && !stat_o) |-> (low_run < RDY_WAIT));

  // R7
  ack_only_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !stat_o) |-> acc_act);

  // R10
  mode_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_sel) |-> (cs_n == 2'b11 && $past(cs_n) == 2'b11));
endmodule

bind hostport_top hp_checker #(.RDY_WAIT(RDY_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
  .bus_oe(bus_oe), .stat_o(stat_o), .host_commit(host_commit),
  .reg_we(reg_we), .ser_req(ser_req), .ser_gnt(ser_gnt), .acc_act(acc_act)
);

// File: tb/tb_hostport_top.sv
`timescale 1ns/1ps
module tb_hostport_top;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int W  = 4;
  localparam int HOLD = W + 6;

  logic clk = 0, rst_n = 0;
  logic mode_sel = 0;
  logic [1:0] cs_n = 2'b11;
  logic strb_a_n = 1, strb_b = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] bus_din = '0, bus_dout;
  logic bus_oe, stat_o;
  logic ser_req = 0, ser_we = 0, ser_bank = 0;
  logic [AW-1:0] ser_addr = '0;
  logic [DW-1:0] ser_wdata = '0, ser_rdata;
  logic ser_gnt, reg_we, reg_bank;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;

  int checks = 0, fails = 0;
  int we_cnt = 0, deny_cnt = 0;
  logic lw_bank; logic [AW-1:0] lw_addr; logic [DW-1:0] lw_data;
  bit done = 0;

  always #2 clk = ~clk;

  hostport_top #(.AW(AW), .DW(DW), .RDY_WAIT(W)) dut (.*);

  always @(negedge clk) begin
    if (reg_we) begin
      we_cnt++; lw_bank = reg_bank; lw_addr = reg_addr; lw_data = reg_wdata;
    end
    if (ser_req && !ser_gnt) deny_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int m, input int b, input int a);
    return 8'((m * 64 + b * 32 + a * 5 + 3) & 255);
  endfunction

  function automatic logic [1:0] csv(input int b);
    return (b == 1) ? 2'b01 : 2'b10;
  endfunction

  // one host access; stat trace summarised as high-before-low and low counts
  task automatic access(input bit rd, input logic [1:0] c, input int a,
                        input logic [7:0] d, output logic [7:0] rv,
                        output logic oe_v, output int hi_pre, output int lo_n,
                        output logic stat_after, output logic oe_after);
    bit seen_low = 0;
    hi_pre = 0; lo_n = 0;
    @(negedge clk);
    cs_n = c; addr = AW'(a); bus_din = d;
    if (mode_sel == 0) begin strb_a_n = rd ? 1'b0 : 1'b1; strb_b = rd ? 1'b1 : 1'b0; end
    else begin strb_a_n = 1'b0; strb_b = rd; end
    for (int i = 1; i <= HOLD; i++) begin
      @(negedge clk);
      if (stat_o == 0) begin lo_n++; seen_low = 1; end
      else if (!seen_low) hi_pre++;
      if (i == 3) begin rv = bus_dout; oe_v = bus_oe; end
    end
    strb_a_n = 1; strb_b = 1;
    for (int i = 1; i <= 3; i++) @(negedge clk);
    stat_after = stat_o; oe_after = bus_oe;
    cs_n = 2'b11;
    for (int i = 1; i <= 3; i++) @(negedge clk);
  endtask

  logic [7:0] rv; logic oe_v, st_a, oe_a; int hp, ln, wc0, dc0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(bus_oe == 0, "R9 oe", bus_oe, 0);
    chk(stat_o == 1, "R9 stat", stat_o, 1);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 8; a++) begin
        ser_bank = b[0]; ser_addr = AW'(a); #1;
        chk(ser_rdata == 0, "R9 reg zero", ser_rdata, 0);
      end

    for (int m = 0; m < 2; m++) begin
      // R10: switch mode only while both selects are high
      @(negedge clk); mode_sel = m[0];
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < 8; a++) begin
          wc0 = we_cnt;
          access(0, csv(b), a, pat(m, b, a), rv, oe_v, hp, ln, st_a, oe_a);
          // R2 / R3 write port, R4 bank
          chk(we_cnt == wc0 + 1, m ? "R3 we pulse" : "R2 we pulse", we_cnt - wc0, 1);
          chk(lw_bank == b[0] && lw_addr == AW'(a) && lw_data == pat(m, b, a),
              "R4 write fields", lw_data, pat(m, b, a));
          chk(oe_v == 0, "R1 oe on write", oe_v, 0);
        end
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < 8; a++) begin
          access(1, csv(b), a, 8'h00, rv, oe_v, hp, ln, st_a, oe_a);
          chk(oe_v == 1 && rv == pat(m, b, a), m ? "R3 read" : "R1 read", rv, pat(m, b, a));
          chk(oe_a == 0, "R1 oe release", oe_a, 0);
          if (m == 0) begin
            chk(hp == 2, "R6 ready delay", hp, 2);
            chk(ln == W, "R6 ready low", ln, W);
          end else begin
            chk(hp == W + 2, "R7 ack delay", hp, W + 2);
            chk(ln == HOLD - W - 2, "R7 ack held", ln, HOLD - W - 2);
            chk(st_a == 1, "R7 ack release", st_a, 1);
          end
        end
      // R5 conflicting selects
      wc0 = we_cnt;
      access(0, 2'b00, 2, 8'hEE, rv, oe_v, hp, ln, st_a, oe_a);
      chk(we_cnt == wc0, "R5 no write", we_cnt - wc0, 0);
      chk(ln == 0, "R5 status idle", ln, 0);
      access(1, 2'b00, 2, 8'h00, rv, oe_v, hp, ln, st_a, oe_a);
      chk(oe_v == 0, "R5 bus quiet", oe_v, 0);
      ser_bank = 0; ser_addr = 2; #1;
      chk(ser_rdata == pat(m, 0, 2), "R5 contents kept", ser_rdata, pat(m, 0, 2));
    end

    // R8 serial write, then contention with a host commit
    @(negedge clk); mode_sel = 0;
    ser_req = 1; ser_we = 1; ser_bank = 1; ser_addr = 5; ser_wdata = 8'h5A;
    @(negedge clk);
    ser_req = 0; ser_we = 0; #1;
    chk(ser_rdata == 8'h5A, "R8 serial write", ser_rdata, 8'h5A);
    access(1, csv(1), 5, 8'h00, rv, oe_v, hp, ln, st_a, oe_a);
    chk(rv == 8'h5A, "R8 host sees serial data", rv, 8'h5A);
    @(negedge clk);
    ser_req = 1; ser_we = 1; ser_bank = 0; ser_addr = 7; ser_wdata = 8'h77;
    dc0 = deny_cnt;
    access(0, csv(0), 6, 8'h66, rv, oe_v, hp, ln, st_a, oe_a);
    ser_req = 0; ser_we = 0;
    chk(deny_cnt - dc0 == 1, "R8 grant drop", deny_cnt - dc0, 1);
    ser_addr = 6; #1;
    chk(ser_rdata == 8'h66, "R8 host write wins", ser_rdata, 8'h66);
    ser_addr = 7; #1;
    chk(ser_rdata == 8'h77, "R8 serial write kept", ser_rdata, 8'h77);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule